// File: doc/BRIEF.md
# Quad-Rate Burst-Four SRAM Sequencer

This block is a synthesizable behavioural model of a burst SRAM that has a read data port and a write data port but only one address bus. Every transfer moves four data words, and data moves on both halves of the input clock. The model uses a single edge clock, `clk`, with one rising edge for every half period of the input clock pair. An internal phase bit labels the edges alternately as K edges (even, the first edge after reset) and K# edges (odd). Commands are sampled only on K edges. Write data is taken on every edge while a write burst is running. Read data is launched on every edge while a read burst is running, either from the K/K# edges or, when the output clock pair is running, only on edges that carry a C/C# rising edge (`cq_tick`).

A read engine and a write engine run independently of each other. Each one is the same burst state machine, with states IDLE, B0, B1, B2 and B3:

| Transition | Condition |
|---|---|
| IDLE → B0 | request active on a K edge; the base address is latched |
| B0 → B1 | always |
| B1 → B2 | always; this is a K edge, and any request seen here is dropped |
| B2 → B3 | always |
| B3 → B0 | request active; this is a K edge, and a new base address is latched |
| B3 → IDLE | no request |

Each state from B0 to B3 issues one beat address. The beat address keeps the upper bits of the base address and adds 0, 1, 2 or 3 to its low two bits, wrapping within those two bits. Write beats pass through one pipeline register and are then merged into the array lane by lane. Read beats pass through two pipeline registers, and the array is read at the moment the beat is launched. Because the array is read at launch, a read that overlaps a write to the same address returns the new data.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset, `q_oe` is 0 and `q` is 0, and both engines are idle.
- R2: A request is accepted only when its active-low pin is low on a K edge. A request on a K# edge is ignored. A request of the same kind at the K edge one K cycle into a running burst is ignored.
- R3: A read accepted at edge e drives beats on edges e+3, e+4, e+5 and e+6. The words come from base+0 through base+3, counted in the low two address bits only, so base 5 reads 5, 6, 7, 4.
- R4: A write accepted at edge e stores the data presented on edges e+2, e+3, e+4 and e+5 to base+0 through base+3, using the same 2-bit wrap as reads.
- R5: A read accepted at edge e+4 behind a read at edge e streams its four beats on edges e+7 to e+10 with no gap, and `q_oe` stays 1 throughout.
- R6: `bw_n[i]`, active low, is sampled on every write beat and gates bits 9i+8 down to 9i. Lanes whose enable is inactive keep their stored value. A beat with all four enables high leaves the word unchanged.
- R7: When `out_on_k` is 1, `q` and `q_oe` update on every edge and `cq_tick` is ignored. When `out_on_k` is 0, they update only on edges where `cq_tick` is 1 and hold their values otherwise.
- R8: On the first launch edge after the last beat, with no read following, `q_oe` goes to 0 and `q` to 0. `q` is 0 whenever `q_oe` is 0.
- R9: A read and a write accepted on the same K edge both proceed. A read that overlaps a write to the same addresses returns the newly written beats.
- R10: A write request during a running write burst is ignored: its address and data are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Edge clock; each rising edge is one K or K# edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_n | input | 1 | Read request, active low |
| wr_n | input | 1 | Write request, active low |
| addr | input | AW | Shared burst base address |
| d | input | LANES*LANE_W | Write data beat |
| bw_n | input | LANES | Per-lane write enables, active low |
| out_on_k | input | 1 | 1: launch output from K/K# edges |
| cq_tick | input | 1 | Output clock pair has a rising edge at this edge |
| q | output | LANES*LANE_W | Read data beat, 0 while disabled |
| q_oe | output | 1 | Output drive enable (0 means high impedance) |

## Verification
An engine stuck in the wrong state shows up at the ports within one K cycle. A missed or duplicated transition shifts the burst window, so `q_oe` rises or falls one edge off, a stream gets a gap, or an ignored request starts a fresh burst. A wrong beat index or wrap appears as the wrong word on the very beat it affects. A misaligned write pipeline corrupts the word read back by the next burst. Dropped forwarding appears as stale data on the first beat of an overlapping read, three edges after the command.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    typedef enum logic [2:0] {
        BST_IDLE,
        BST_B0,
        BST_B1,
        BST_B2,
        BST_B3
    } burst_st_t;

endpackage

// File: rtl/qdr_burst_fsm.sv
module qdr_burst_fsm
    import qdr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          k_edge,
    input  logic          req,
    input  logic [AW-1:0] base_in,
    output logic          issue_vld,
    output logic [AW-1:0] issue_addr
);

    burst_st_t     st, st_nx;
    logic [AW-1:0] base_q;
    logic          take;
    logic [1:0]    idx;

    // next state
    always_comb begin
        st_nx = st;
        take  = 1'b0;
        unique case (st)
            BST_IDLE: begin
                if (k_edge && req) begin
                    st_nx = BST_B0;
                    take  = 1'b1;
                end
            end
            BST_B0: st_nx = BST_B1;
            BST_B1: st_nx = BST_B2;
            BST_B2: st_nx = BST_B3;
            BST_B3: begin
                if (req) begin
                    st_nx = BST_B0;
                    take  = 1'b1;
                end else begin
                    st_nx = BST_IDLE;
                end
            end
            default: st_nx = BST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BST_IDLE;
            base_q <= '0;
        end else begin
            st <= st_nx;
            if (take) begin
                base_q <= base_in;
            end
        end
    end

    // outputs
    always_comb begin
        issue_vld = 1'b1;
        idx       = 2'd0;
        unique case (st)
            BST_IDLE: issue_vld = 1'b0;
            BST_B0:   idx = 2'd0;
            BST_B1:   idx = 2'd1;
            BST_B2:   idx = 2'd2;
            BST_B3:   idx = 2'd3;
            default:  issue_vld = 1'b0;
        endcase
        issue_addr = {base_q[AW-1:2], 2'(base_q[1:0] + idx)};
    end

    // R2: the busy-window state and the restart state must fall on K edges
    k_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BST_B1 || st == BST_B3) |-> k_edge);

    // R3
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BST_B0) |=> (st == BST_B1));

endmodule

// File: rtl/qdr_lane_array.sv
module qdr_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH = 1 << AW,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wdata,
    input  logic [LANES-1:0] wbe_n,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wbe_n[l]) begin
                lane_mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/qdr_read_launch.sv
module qdr_read_launch #(
    parameter int AW = 6,
    parameter int W  = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_vld,
    input  logic [AW-1:0] issue_addr,
    input  logic          launch_en,
    output logic [AW-1:0] arr_raddr,
    input  logic [W-1:0]  arr_rdata,
    output logic [W-1:0]  q,
    output logic          q_oe
);

    logic          p1_vld, p2_vld;
    logic [AW-1:0] p1_addr, p2_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_vld  <= 1'b0;
            p2_vld  <= 1'b0;
            p1_addr <= '0;
            p2_addr <= '0;
            q       <= '0;
            q_oe    <= 1'b0;
        end else begin
            p1_vld  <= issue_vld;
            p1_addr <= issue_addr;
            p2_vld  <= p1_vld;
            p2_addr <= p1_addr;
            if (launch_en) begin
                q_oe <= p2_vld;
                q    <= p2_vld ? arr_rdata : '0;
            end
        end
    end

    assign arr_raddr = p2_addr;

    // R8
    hiz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q == '0));

    // R7
    launch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_en |=> ($stable(q) && $stable(q_oe)));

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     d,
    input  logic [LANES-1:0] bw_n,
    input  logic             out_on_k,
    input  logic             cq_tick,
    output logic [W-1:0]     q,
    output logic             q_oe
);

    logic          ph;
    logic          k_edge;
    logic          rd_issue_vld, wr_issue_vld;
    logic [AW-1:0] rd_issue_addr, wr_issue_addr;
    logic          wp_vld;
    logic [AW-1:0] wp_addr;
    logic [AW-1:0] arr_raddr;
    logic [W-1:0]  arr_rdata;

    // edge phase: 0 marks a K edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= 1'b0;
        end else begin
            ph <= ~ph;
        end
    end
    assign k_edge = (ph == 1'b0);

    qdr_burst_fsm #(.AW(AW)) u_rd_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .k_edge     (k_edge),
        .req        (~rd_n),
        .base_in    (addr),
        .issue_vld  (rd_issue_vld),
        .issue_addr (rd_issue_addr)
    );

    qdr_burst_fsm #(.AW(AW)) u_wr_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .k_edge     (k_edge),
        .req        (~wr_n),
        .base_in    (addr),
        .issue_vld  (wr_issue_vld),
        .issue_addr (wr_issue_addr)
    );

    // one stage so that the beat address meets its data edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_vld  <= 1'b0;
            wp_addr <= '0;
        end else begin
            wp_vld  <= wr_issue_vld;
            wp_addr <= wr_issue_addr;
        end
    end

    qdr_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (wp_vld),
        .waddr (wp_addr),
        .wdata (d),
        .wbe_n (bw_n),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    qdr_read_launch #(.AW(AW), .W(W)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_vld  (rd_issue_vld),
        .issue_addr (rd_issue_addr),
        .launch_en  (out_on_k | cq_tick),
        .arr_raddr  (arr_raddr),
        .arr_rdata  (arr_rdata),
        .q          (q),
        .q_oe       (q_oe)
    );

    // R4: first write beat is stored on a K edge
    wbeat_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wp_vld) |-> k_edge);

    // R3: in K launch mode the first read beat follows a K# edge
    rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q_oe) && $past(out_on_k)) |-> k_edge);

endmodule

// File: tb/qdr_burst_sram_bench.sv
module qdr_burst_sram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [35:0] d = '0;
    logic [3:0]  bw_n = 4'hF;
    logic        out_on_k = 1'b1;
    logic        cq_tick = 1'b0;
    logic [35:0] q;
    logic        q_oe;

    int n_chk = 0;
    int n_fail = 0;
    int next_e = 0;
    bit done = 1'b0;
    logic [35:0] ref_mem [64];

    always #2.5 clk = ~clk;

    qdr_burst_sram u_qdr_burst_sram (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .d(d), .bw_n(bw_n), .out_on_k(out_on_k), .cq_tick(cq_tick),
        .q(q), .q_oe(q_oe)
    );

    function automatic logic [35:0] pat(input int s, input int i);
        return {8'(s), 4'(i), 24'(s * 40503 + i * 7919)};
    endfunction

    function automatic logic [5:0] baddr(input logic [5:0] b, input int i);
        return {b[5:2], 2'(b[1:0] + 2'(i))};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        next_e++;
    endtask

    task automatic align_k();
        if (next_e % 2 == 1) step();
    endtask

    function automatic void ref_write(input logic [5:0] a, input logic [35:0] v, input logic [3:0] be_n);
        for (int l = 0; l < 4; l++)
            if (!be_n[l]) ref_mem[a][l*9 +: 9] = v[l*9 +: 9];
    endfunction

    // bwv holds four beats of enables, beat 0 in bits 3:0
    task automatic do_write(input logic [5:0] base, input int seed, input logic [15:0] bwv);
        align_k();
        wr_n = 1'b0; addr = base;
        step();
        wr_n = 1'b1;
        step();
        for (int i = 0; i < 4; i++) begin
            d = pat(seed, i); bw_n = bwv[i*4 +: 4];
            ref_write(baddr(base, i), d, bw_n);
            step();
        end
        bw_n = 4'hF; d = '0;
    endtask

    task automatic read_check(input logic [5:0] base, input string tag);
        align_k();
        rd_n = 1'b0; addr = base;
        step();
        rd_n = 1'b1;
        step();
        step();
        for (int i = 0; i < 4; i++) begin
            step();
            check({tag, " beat data"}, q, ref_mem[baddr(base, i)]);
            check({tag, " beat oe"}, 36'(q_oe), 36'd1);
        end
        step();
        check("R8 oe after burst", 36'(q_oe), 36'd0);
        check("R8 q after burst", q, 36'd0);
    endtask

    task automatic t_reset();
        check("R1 oe after reset", 36'(q_oe), 36'd0);
        check("R1 q after reset", q, 36'd0);
        step(); step();
        check("R1 idle oe", 36'(q_oe), 36'd0);
    endtask

    task automatic t_write_read();
        do_write(6'd8, 3, 16'h0000);
        read_check(6'd8, "R4 R3 full write then read");
    endtask

    task automatic t_wrap();
        do_write(6'd6, 4, 16'h0000);
        read_check(6'd5, "R3 wrap read base 5");
        read_check(6'd6, "R4 wrap write base 6");
    endtask

    task automatic t_lanes();
        do_write(6'd12, 5, 16'h0000);
        // beat0 lane0 only, beat1 lane3 only, beat2 none, beat3 lanes 0 and 2
        do_write(6'd12, 6, {4'b1010, 4'b1111, 4'b0111, 4'b1110});
        read_check(6'd12, "R6 lane merge");
    endtask

    task automatic t_kbar_ignored();
        do_write(6'd48, 7, 16'h0000);
        align_k();
        step();
        rd_n = 1'b0; wr_n = 1'b0; addr = 6'd48; d = pat(9, 0); bw_n = 4'h0;
        step();
        rd_n = 1'b1; wr_n = 1'b1;
        for (int k = 0; k < 7; k++) begin
            d = pat(9, k + 1);
            step();
            check("R2 no read from K# request", 36'(q_oe), 36'd0);
        end
        bw_n = 4'hF; d = '0;
        read_check(6'd48, "R2 no write from K# request");
    endtask

    task automatic t_busy_read();
        do_write(6'd20, 10, 16'h0000);
        align_k();
        rd_n = 1'b0; addr = 6'd16;
        step();
        rd_n = 1'b1;
        step();
        rd_n = 1'b0; addr = 6'd20;
        step();
        rd_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R2 busy read keeps first burst", q, ref_mem[baddr(6'd16, i)]);
        end
        step();
        check("R2 busy read ignored oe", 36'(q_oe), 36'd0);
        step();
        check("R2 busy read ignored stays off", 36'(q_oe), 36'd0);
    endtask

    task automatic t_b2b();
        do_write(6'd16, 11, 16'h0000);
        do_write(6'd24, 12, 16'h0000);
        align_k();
        for (int k = 0; k <= 11; k++) begin
            rd_n = (k == 0 || k == 4) ? 1'b0 : 1'b1;
            addr = (k == 0) ? 6'd16 : 6'd24;
            step();
            if (k >= 3 && k <= 6)
                check("R5 stream first", q, ref_mem[baddr(6'd16, k - 3)]);
            if (k >= 7 && k <= 10)
                check("R5 stream second", q, ref_mem[baddr(6'd24, k - 7)]);
            if (k >= 3 && k <= 10)
                check("R5 oe no gap", 36'(q_oe), 36'd1);
        end
        rd_n = 1'b1;
        check("R8 oe after stream", 36'(q_oe), 36'd0);
    endtask

    task automatic t_busy_write();
        do_write(6'd32, 13, 16'h0000);
        align_k();
        wr_n = 1'b0; addr = 6'd28;
        step();
        wr_n = 1'b1;
        step();
        for (int i = 0; i < 4; i++) begin
            if (i == 0) begin wr_n = 1'b0; addr = 6'd32; end
            else wr_n = 1'b1;
            d = pat(14, i); bw_n = 4'h0;
            ref_write(baddr(6'd28, i), d, bw_n);
            step();
        end
        wr_n = 1'b1;
        d = pat(15, 0);
        for (int i = 0; i < 4; i++) step();
        bw_n = 4'hF; d = '0;
        read_check(6'd28, "R10 first write intact");
        read_check(6'd32, "R10 busy write ignored");
    endtask

    task automatic t_concurrent();
        do_write(6'd40, 16, 16'h0000);
        align_k();
        rd_n = 1'b0; wr_n = 1'b0; addr = 6'd40;
        step();
        rd_n = 1'b1; wr_n = 1'b1;
        step();
        for (int k = 2; k <= 7; k++) begin
            if (k <= 5) begin
                d = pat(17, k - 2); bw_n = 4'h0;
                ref_write(baddr(6'd40, k - 2), d, bw_n);
            end else begin
                bw_n = 4'hF; d = '0;
            end
            step();
            if (k >= 3 && k <= 6)
                check("R9 forwarded new write data", q, pat(17, k - 3));
            if (k == 7)
                check("R8 oe after concurrent read", 36'(q_oe), 36'd0);
        end
        read_check(6'd40, "R9 write completed alongside read");
    endtask

    task automatic t_cmode();
        out_on_k = 1'b0;
        cq_tick = 1'b1;
        align_k();
        rd_n = 1'b0; addr = 6'd8;
        step();
        rd_n = 1'b1;
        step(); step(); step();
        check("R7 C mode beat0", q, ref_mem[baddr(6'd8, 0)]);
        cq_tick = 1'b0;
        step();
        check("R7 no tick holds q", q, ref_mem[baddr(6'd8, 0)]);
        check("R7 no tick holds oe", 36'(q_oe), 36'd1);
        cq_tick = 1'b1;
        step();
        check("R7 C mode beat2", q, ref_mem[baddr(6'd8, 2)]);
        step();
        check("R7 C mode beat3", q, ref_mem[baddr(6'd8, 3)]);
        step();
        check("R8 C mode oe off", 36'(q_oe), 36'd0);
        out_on_k = 1'b1;
        cq_tick = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        next_e = 0;
        t_reset();
        t_write_read();
        t_wrap();
        t_lanes();
        t_kbar_ignored();
        t_busy_read();
        t_b2b();
        t_busy_write();
        t_concurrent();
        t_cmode();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..all act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule